// File: doc/BRIEF.md
# Audio Serial Output Formatter

This block turns decoded audio subframes into a framed serial audio stream. An upstream biphase decoder hands it one sample word per subframe, a flag naming the channel, and a flag saying whether the subframe passed its parity check. The block keeps the most recent accepted word for each channel and shifts those words out on a serial data line. Alongside the data it drives a bit clock, a left/right word clock, a 256Fs clock and a 384Fs clock. All of these outputs derive from one master clock, so they stay phase-aligned to the data.

The master clock runs at 768 times the sample rate. One frame lasts 768 master cycles and holds 64 bit slots, 32 for each channel. A format input selects one of two word layouts. In the wide layout, 20-bit words go out least-significant bit first. In the narrow layout, the top 16 bits of the word go out most-significant bit first. In both layouts the word is right-justified in its 32 slots and the leading slots are zero.

A subframe that fails its check is never emitted. The block keeps sending the last accepted word for that channel. The format input is sampled only where a right channel ends and a left channel begins, so no word is ever emitted with mixed bit order.

Top module: `audio_fmt_out`

## Requirements
- R1: With the format latched high, each channel's 32 slots carry 12 zeros in slots 0 to 11, then word bits 0 to 19 in slots 12 to 31 (least-significant bit first).
- R2: With the format latched low, each channel's 32 slots carry 16 zeros in slots 0 to 15, then word bits 19 down to 4 in slots 16 to 31 (most-significant bit first).
- R3: The bit clock has a period of 12 master cycles (low for 6, then high for 6), giving 64 bit periods per frame. Serial data and the word clock change only at falling edges of the bit clock.
- R4: The word clock is high during the left channel (slots 0 to 31) and low during the right channel (slots 32 to 63).
- R5: A subframe presented with sub_ok_i low leaves that channel's stored word unchanged. The previously accepted word is emitted in its place. A subframe with sub_ok_i high replaces only the word of the channel named by sub_left_i (1 = left).
- R6: The 256Fs clock repeats every 3 master cycles, high for 2 and low for 1. The 384Fs clock repeats every 2 master cycles, high for 1 and low for 1. Both start their high phase on the master cycle where a frame begins.
- R7: A synchronous active-low reset clears both stored words and the format register (narrow layout) and restarts the frame at slot 0. While reset is held, the outputs read: word clock 1, bit clock 0, data 0, 256Fs 1, 384Fs 1.
- R8: A change of the format input takes effect only at the next frame start (left-channel boundary). A change made during the left half leaves the rest of that frame in the old layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 768 x Fs |
| rst_n | input | 1 | Synchronous reset, active low |
| sub_valid_i | input | 1 | One-cycle strobe: a decoded subframe is presented |
| sub_left_i | input | 1 | Channel of the subframe: 1 = left, 0 = right |
| sub_ok_i | input | 1 | Subframe passed its parity check |
| sub_word_i | input | SAMPLE_W | Decoded sample word |
| fmt_lsb20_i | input | 1 | Format select: 1 = 20-bit LSB first, 0 = 16-bit MSB first |
| bclk_o | output | 1 | Bit clock, 64 x Fs |
| lrck_o | output | 1 | Word clock: high = left, low = right |
| sdata_o | output | 1 | Serial audio data |
| fs256_o | output | 1 | 256 x Fs clock, duty 2:1 |
| fs384_o | output | 1 | 384 x Fs clock, duty 1:1 |

## Verification
The bench builds the block with its defaults: 20-bit sample words and 16-bit narrow words, set in 32-slot channels. With these values the wide layout has 12 padding slots and the narrow layout has 16. A word whose extreme bits are set therefore shows at once whether an off-by-one shift has moved a bit into the padding or dropped it. Because a frame is 768 master cycles long, every clock ratio and phase relationship can be checked cycle by cycle over a whole frame. The vector table alternates good and corrupted subframes on each channel while flipping the format, so held words are checked in both bit orders.

// File: rtl/afmt_pkg.sv
// Package: shared constants and the format type for the audio output formatter.
// Assumes the master clock runs at 768 x Fs. Every derived clock below depends on that ratio.
package afmt_pkg;
    // Master cycles per serial bit: 768 / 64.
    localparam int CLK_PER_BIT  = 12;
    // Bit slots in each channel half of a frame.
    localparam int SLOTS_PER_CH = 32;

    typedef enum logic {
        FMT_MSB16 = 1'b0,
        FMT_LSB20 = 1'b1
    } fmt_e;
endpackage

// File: rtl/afmt_timebase.sv
// Module: afmt_timebase
// Divides the 768 x Fs master clock into the bit clock, the word clock and the
// 256Fs and 384Fs clocks, and gives out the slot position and the channel and
// frame end strobes.
// Assumes CLK_PER_BIT is even and 2*SLOTS_PER_CH*CLK_PER_BIT is a multiple of 6,
// so that the 2- and 3-cycle clocks realign at every frame start.
module afmt_timebase
    import afmt_pkg::*;
#(
    parameter int BIT_CLKS = CLK_PER_BIT,
    parameter int CH_SLOTS = SLOTS_PER_CH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    output logic [$clog2(CH_SLOTS)-1:0]  ch_slot_o,
    output logic                         ch_end_o,
    output logic                         frame_end_o,
    output logic                         bclk_o,
    output logic                         lrck_o,
    output logic                         fs256_o,
    output logic                         fs384_o
);
    localparam int SUB_W   = $clog2(BIT_CLKS);
    localparam int CH_W    = $clog2(CH_SLOTS);
    localparam int SLOT_W  = CH_W + 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(BIT_CLKS - 1);
    localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(BIT_CLKS / 2);

    logic [SUB_W-1:0]  sub_q;
    logic [SLOT_W-1:0] slot_q;
    logic              ph2_q;
    logic [1:0]        ph3_q;
    logic              bit_end;

    assign bit_end = (sub_q == SUB_LAST);

    // Purpose: advance the in-bit counter and the frame slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= '0;
            slot_q <= '0;
        end else begin
            sub_q <= bit_end ? '0 : sub_q + 1'b1;
            if (bit_end) slot_q <= slot_q + 1'b1;
        end
    end

    // Purpose: run the modulo-2 and modulo-3 phases for 384Fs and 256Fs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph2_q <= 1'b0;
            ph3_q <= 2'd0;
        end else begin
            ph2_q <= ~ph2_q;
            ph3_q <= (ph3_q == 2'd2) ? 2'd0 : ph3_q + 2'd1;
        end
    end

    assign ch_slot_o   = slot_q[CH_W-1:0];
    assign ch_end_o    = bit_end && (slot_q[CH_W-1:0] == {CH_W{1'b1}});
    assign frame_end_o = ch_end_o && slot_q[SLOT_W-1];
    assign bclk_o      = (sub_q >= SUB_HALF);
    assign lrck_o      = ~slot_q[SLOT_W-1];
    assign fs256_o     = (ph3_q != 2'd2);
    assign fs384_o     = ~ph2_q;

    // R3
    word_clk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lrck_o != $past(lrck_o)) |-> ($past(bclk_o) && !bclk_o));
    // R6
    fs256_low_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs256_o |=> fs256_o);
    // R6
    fs256_high_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fs256_o) |-> $past(fs256_o, 2));
endmodule

// File: rtl/afmt_hold.sv
// Module: afmt_hold
// Keeps the last accepted sample word for each channel. A register loads only
// when a subframe strobe arrives with a good check flag.
// Assumes at most one subframe strobe per cycle.
module afmt_hold #(
    parameter int SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic                left_i,
    input  logic                ok_i,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic [SAMPLE_W-1:0] hold_l_o,
    output logic [SAMPLE_W-1:0] hold_r_o
);
    logic accept;
    assign accept = valid_i && ok_i;

    // Purpose: store good words per channel and drop corrupted ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l_o <= '0;
            hold_r_o <= '0;
        end else if (accept) begin
            if (left_i) hold_l_o <= word_i;
            else        hold_r_o <= word_i;
        end
    end

    // R5
    bad_sub_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && ok_i) |=> ($stable(hold_l_o) && $stable(hold_r_o)));
    // R5
    other_ch_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && left_i) |=> $stable(hold_r_o));
endmodule

// File: rtl/afmt_serial.sv
// Module: afmt_serial
// Latches the word of the next channel at each channel end, latches the format
// at each frame end, and picks the serial bit for the current slot.
// Assumes NARROW_W <= SAMPLE_W <= CH_SLOTS. The narrow layout sends the top bits.
module afmt_serial
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int NARROW_W = 16,
    parameter int CH_SLOTS = SLOTS_PER_CH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(CH_SLOTS)-1:0]  ch_slot_i,
    input  logic                         ch_end_i,
    input  logic                         frame_end_i,
    input  logic                         bclk_i,
    input  logic [SAMPLE_W-1:0]          hold_l_i,
    input  logic [SAMPLE_W-1:0]          hold_r_i,
    input  logic                         fmt_i,
    output logic                         sdata_o
);
    localparam int PAD_WIDE   = CH_SLOTS - SAMPLE_W;
    localparam int PAD_NARROW = CH_SLOTS - NARROW_W;
    localparam int IDX_W      = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] word_q;
    fmt_e                fmt_q;
    int                  pos;

    // Purpose: take the next channel's word at each channel end.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (ch_end_i) word_q <= frame_end_i ? hold_l_i : hold_r_i;
    end

    // Purpose: sample the format only where a new left channel begins.
    always_ff @(posedge clk) begin
        if (!rst_n)           fmt_q <= FMT_MSB16;
        else if (frame_end_i) fmt_q <= fmt_e'(fmt_i);
    end

    // Purpose: map the slot to a word bit, with zeros in the padding slots.
    always_comb begin
        pos     = int'(ch_slot_i);
        sdata_o = 1'b0;
        if (fmt_q == FMT_LSB20) begin
            if (pos >= PAD_WIDE)
                sdata_o = word_q[IDX_W'(pos - PAD_WIDE)];
        end else begin
            if (pos >= PAD_NARROW)
                sdata_o = word_q[IDX_W'(SAMPLE_W - 1 - (pos - PAD_NARROW))];
        end
    end

    // R3
    data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_o != $past(sdata_o)) |-> ($past(bclk_i) && !bclk_i));
    // R8
    fmt_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_q != $past(fmt_q)) |-> $past(frame_end_i));
    // R5
    word_at_ch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q != $past(word_q)) |-> $past(ch_end_i));
endmodule

// File: rtl/audio_fmt_out.sv
// Module: audio_fmt_out (top)
// Formats decoded audio subframes into bit clock, word clock and serial data,
// substitutes held words for corrupted subframes, and gives out 256Fs and 384Fs clocks.
// Assumes clk = 768 x Fs and subframes arrive at least one frame before they are due.
module audio_fmt_out
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int NARROW_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sub_valid_i,
    input  logic                sub_left_i,
    input  logic                sub_ok_i,
    input  logic [SAMPLE_W-1:0] sub_word_i,
    input  logic                fmt_lsb20_i,
    output logic                bclk_o,
    output logic                lrck_o,
    output logic                sdata_o,
    output logic                fs256_o,
    output logic                fs384_o
);
    localparam int CH_W = $clog2(SLOTS_PER_CH);

    logic [CH_W-1:0]     ch_slot;
    logic                ch_end;
    logic                frame_end;
    logic [SAMPLE_W-1:0] hold_l;
    logic [SAMPLE_W-1:0] hold_r;

    afmt_timebase #(
        .BIT_CLKS (CLK_PER_BIT),
        .CH_SLOTS (SLOTS_PER_CH)
    ) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_slot_o   (ch_slot),
        .ch_end_o    (ch_end),
        .frame_end_o (frame_end),
        .bclk_o      (bclk_o),
        .lrck_o      (lrck_o),
        .fs256_o     (fs256_o),
        .fs384_o     (fs384_o)
    );

    afmt_hold #(
        .SAMPLE_W (SAMPLE_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (sub_valid_i),
        .left_i   (sub_left_i),
        .ok_i     (sub_ok_i),
        .word_i   (sub_word_i),
        .hold_l_o (hold_l),
        .hold_r_o (hold_r)
    );

    afmt_serial #(
        .SAMPLE_W (SAMPLE_W),
        .NARROW_W (NARROW_W),
        .CH_SLOTS (SLOTS_PER_CH)
    ) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_slot_i   (ch_slot),
        .ch_end_i    (ch_end),
        .frame_end_i (frame_end),
        .bclk_i      (bclk_o),
        .hold_l_i    (hold_l),
        .hold_r_i    (hold_r),
        .fmt_i       (fmt_lsb20_i),
        .sdata_o     (sdata_o)
    );
endmodule

// File: tb/audio_fmt_out_tb.sv
module audio_fmt_out_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sub_valid_i = 1'b0;
    logic        sub_left_i = 1'b0;
    logic        sub_ok_i = 1'b0;
    logic [19:0] sub_word_i = '0;
    logic        fmt_lsb20_i = 1'b0;
    logic        bclk_o, lrck_o, sdata_o, fs256_o, fs384_o;

    int n_vec = 0;
    int n_err = 0;
    logic [19:0] m_l = '0, m_r = '0;

    always #4 clk = ~clk;

    audio_fmt_out u_dut (
        .clk(clk), .rst_n(rst_n), .sub_valid_i(sub_valid_i), .sub_left_i(sub_left_i),
        .sub_ok_i(sub_ok_i), .sub_word_i(sub_word_i), .fmt_lsb20_i(fmt_lsb20_i),
        .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o),
        .fs256_o(fs256_o), .fs384_o(fs384_o)
    );

    // {mode, left ok, right ok, left word, right word}
    localparam logic [42:0] VEC [0:5] = '{
        {1'b1, 1'b1, 1'b1, 20'hA5C3E, 20'h1F2E4},
        {1'b0, 1'b1, 1'b1, 20'h8000F, 20'h7FFF1},
        {1'b1, 1'b0, 1'b1, 20'hFFFFF, 20'h00001},
        {1'b0, 1'b1, 1'b0, 20'h12345, 20'hABCDE},
        {1'b1, 1'b0, 1'b0, 20'h55555, 20'hAAAAA},
        {1'b0, 1'b1, 1'b1, 20'hFFFFF, 20'h80000}
    };

    task automatic chk(input bit good, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_vec++;
        if (!good) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected 32 slots of one channel: bit s is the slot s output (R1, R2).
    function automatic logic [31:0] exp_half(input logic [19:0] w, input logic wide);
        logic [31:0] r = '0;
        for (int s = 0; s < 32; s++) begin
            if (wide && s >= 12)       r[s] = w[s - 12];
            else if (!wide && s >= 16) r[s] = w[19 - (s - 16)];
        end
        return r;
    endfunction

    task automatic send(input logic left, input logic ok, input logic [19:0] w);
        @(negedge clk);
        sub_valid_i = 1'b1; sub_left_i = left; sub_ok_i = ok; sub_word_i = w;
        @(negedge clk);
        sub_valid_i = 1'b0;
    endtask

    // Captures 64 slots. flip_at >= 0 sets the format high after that many slots.
    task automatic capture(output logic [63:0] bits, output logic [63:0] lr,
                           input int flip_at);
        for (int i = 0; i < 64; i++) begin
            @(posedge bclk_o);
            @(negedge clk);
            bits[i] = sdata_o;
            lr[i]   = lrck_o;
            if (i == flip_at) fmt_lsb20_i = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        logic [63:0] bits, lr;
        logic [42:0] v;
        logic        mode;
        int e_b, e_l, e_256, e_384, rises;
        logic prev_b;

        repeat (4) @(negedge clk);
        // R7: output values while reset is held
        chk({lrck_o, bclk_o, sdata_o, fs256_o, fs384_o} == 5'b10011, "R7 reset outputs",
            {59'd0, lrck_o, bclk_o, sdata_o, fs256_o, fs384_o}, 64'b10011);
        rst_n = 1'b1;
        capture(bits, lr, -1);
        chk(bits == 64'd0, "R7 first frame zero", bits, 64'd0);

        // Table walk: R1, R2, R4, R5
        for (int k = 0; k < 6; k++) begin
            v = VEC[k];
            @(posedge lrck_o);
            @(negedge clk);
            fmt_lsb20_i = v[42];
            send(1'b1, v[41], v[39:20]);
            send(1'b0, v[40], v[19:0]);
            if (v[41]) m_l = v[39:20];
            if (v[40]) m_r = v[19:0];
            mode = v[42];
            @(posedge lrck_o);
            capture(bits, lr, -1);
            chk(bits[31:0] == exp_half(m_l, mode), mode ? "R1 R5 left" : "R2 R5 left",
                {32'd0, bits[31:0]}, {32'd0, exp_half(m_l, mode)});
            chk(bits[63:32] == exp_half(m_r, mode), mode ? "R1 R5 right" : "R2 R5 right",
                {32'd0, bits[63:32]}, {32'd0, exp_half(m_r, mode)});
            chk(lr == {32'h0, 32'hFFFF_FFFF}, "R4 word clock", lr, {32'h0, 32'hFFFF_FFFF});
        end

        // R3, R6, R4: cycle-by-cycle clock shapes over one frame
        @(posedge lrck_o);
        e_b = 0; e_l = 0; e_256 = 0; e_384 = 0; rises = 0; prev_b = 1'b0;
        for (int i = 0; i < 768; i++) begin
            @(negedge clk);
            if (bclk_o  != ((i % 12) >= 6)) e_b++;
            if (lrck_o  != (i < 384))       e_l++;
            if (fs256_o != ((i % 3) != 2))  e_256++;
            if (fs384_o != ((i % 2) == 0))  e_384++;
            if (bclk_o && !prev_b) rises++;
            prev_b = bclk_o;
        end
        chk(e_b == 0, "R3 bit clock shape", 64'(e_b), 64'd0);
        chk(rises == 64, "R3 bit clocks per frame", 64'(rises), 64'd64);
        chk(e_l == 0, "R4 word clock shape", 64'(e_l), 64'd0);
        chk(e_256 == 0, "R6 256Fs shape", 64'(e_256), 64'd0);
        chk(e_384 == 0, "R6 384Fs shape", 64'(e_384), 64'd0);

        // R8: format raised during the left half applies only from the next frame
        @(posedge lrck_o);
        capture(bits, lr, 8);
        chk(bits[63:32] == exp_half(m_r, 1'b0), "R8 old format kept",
            {32'd0, bits[63:32]}, {32'd0, exp_half(m_r, 1'b0)});
        capture(bits, lr, -1);
        chk(bits[31:0] == exp_half(m_l, 1'b1), "R8 new format at frame",
            {32'd0, bits[31:0]}, {32'd0, exp_half(m_l, 1'b1)});

        // R7: reset mid-run clears the stored words
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        capture(bits, lr, -1);
        chk(bits == 64'd0, "R7 words cleared", bits, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule